// File: doc/BRIEF.md
# SMBus Block-Read Responder with CRC-8 Packet Error Code

This block is the transaction engine of an SMBus target that serves block reads from a small memory. It watches the synchronised SCL and SDA lines and decodes a write phase that addresses the device and carries the block-read command code. It then waits for a repeated start followed by the same device address with the read bit set. In the read phase it returns a byte count, then that many bytes fetched through a combinational memory read port, and then, when enabled, a CRC-8 packet error code (PEC) computed over every byte of the transaction.

The engine only decides when SDA is pulled low. The pad, clock stretching and any memory programming sit outside it. An unknown command code, a master NACK that comes before the last byte and a stop condition all make the engine release SDA and wait for the next start. The same CRC step logic is applied to received bytes (the addresses and the command) and to transmitted bytes (the count and the data), so the final PEC covers the whole exchange.

Top module: `smb_blk_rd_pec`

## Requirements
- R1: After a start, an address byte equal to {DEV_ADDR, 0} (7-bit address, then a 0 in bit 0) is ACKed by pulling SDA low during the ninth clock. Any other address byte is not ACKed, and the engine stays silent until the next start.
- R2: After an ACKed write address, the command byte 0xFD is ACKed. Any other command byte is NACKed and the engine goes idle. A following repeated start with the read address is then also NACKed.
- R3: After an ACKed 0xFD command, a repeated start followed by {DEV_ADDR, 1} is ACKed. The read address is NACKed when no write phase with the command came before it.
- R4: The first byte returned in the read phase is the count. It is followed by count data bytes taken from rd_addr 0, 1, ..., count-1 in that order. Every byte is sent MSB first.
- R5: The count is blk_len (6 bits) when blk_len is between 1 and 32. A blk_len of 0 or above 32 is sent as 32, and exactly 32 data bytes follow.
- R6: When pec_en is 1 at the read-address ACK, one more byte follows the last data byte. It is the CRC-8 with polynomial 0x07 and initial value 0x00, computed MSB first over the write address byte, the command byte, the read address byte, the count byte and all data bytes.
- R7: Once the final byte has been sent (the PEC byte, or the last data byte when pec_en is 0), the engine releases SDA. If the master keeps clocking, it reads 0xFF.
- R8: When the master NACKs any byte before the final one, the engine stops driving SDA and stays silent until a start or a stop.
- R9: Reset and a stop condition both return the engine to idle with SDA released. A full read after an aborted write phase is served normally.
- R10: sda_oe changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level as seen at the pad |
| sda_i | input | 1 | SDA line level as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| pec_en | input | 1 | Append a PEC byte to the read phase |
| blk_len | input | 6 | Requested block length (0 or above 32 gives 32) |
| rd_addr | output | 5 | Memory read address for the next data byte |
| rd_data | input | 8 | Memory read data for rd_addr, combinational |

## Verification
A wrong state or bit counter shows up on SDA within one byte time. An ACK or data bit lands one SCL clock early or late, and the master sees a shifted byte or a missing ACK at the next ninth clock. A wrong index or CRC register does not show until the byte that depends on it: a data byte, a count byte or, for the CRC, the final PEC byte. For that reason every transaction is checked byte by byte and through its trailing PEC. Release faults show up only when the master clocks after a NACK or at the end of the transfer, so the bench reads one extra byte there and expects all ones.

// File: rtl/smb_blk_pkg.sv
package smb_blk_pkg;
  typedef enum logic [3:0] {
    S_IDLE,   // waiting for a start
    S_ADDR,   // shifting in an address byte
    S_CMD,    // shifting in the command byte
    S_ACK,    // driving the ninth-clock ACK
    S_RSW,    // waiting for the repeated start
    S_TX,     // shifting out a byte
    S_TXACK,  // sampling the master's ACK/NACK
    S_TXNXT,  // loading the next byte on the coming SCL fall
    S_WAIT    // silent until start or stop
  } eng_state_e;
endpackage

// File: rtl/smb_rst_sync.sv
module smb_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_sn
);
  logic meta_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      rst_sn <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      rst_sn <= meta_q;
    end
  end
endmodule

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES:0] scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= {scl_q[STAGES-1:0], scl_i};
      sda_q <= {sda_q[STAGES-1:0], sda_i};
    end
  end

  // index STAGES-1 is the synchronised level, index STAGES the previous one
  assign sda_s     = sda_q[STAGES-1];
  assign scl_rise  =  scl_q[STAGES-1] & ~scl_q[STAGES];
  assign scl_fall  = ~scl_q[STAGES-1] &  scl_q[STAGES];
  assign start_det =  scl_q[STAGES-1] & scl_q[STAGES] & ~sda_q[STAGES-1] &  sda_q[STAGES];
  assign stop_det  =  scl_q[STAGES-1] & scl_q[STAGES] &  sda_q[STAGES-1] & ~sda_q[STAGES];
endmodule

// File: rtl/smb_crc8_step.sv
module smb_crc8_step #(
  parameter logic [7:0] POLY = 8'h07
) (
  input  logic [7:0] crc_i,
  input  logic [7:0] data_i,
  output logic [7:0] crc_o
);
  logic [7:0] acc;

  always_comb begin
    acc = crc_i ^ data_i;
    for (int b = 0; b < 8; b++) begin
      acc = acc[7] ? ({acc[6:0], 1'b0} ^ POLY) : {acc[6:0], 1'b0};
    end
    crc_o = acc;
  end
endmodule

// File: rtl/smb_blk_rd_pec.sv
module smb_blk_rd_pec
  import smb_blk_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h2C,
  parameter logic [7:0] CMD_CODE = 8'hFD,
  parameter int         MAX_LEN  = 32,
  parameter logic [7:0] CRC_POLY = 8'h07,
  localparam int        LEN_W    = $clog2(MAX_LEN + 2),
  localparam int        AW       = $clog2(MAX_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  input  logic             pec_en,
  input  logic [LEN_W-1:0] blk_len,
  output logic [AW-1:0]    rd_addr,
  input  logic [7:0]       rd_data
);
  logic rst_sn;
  logic sda_s, scl_rise, scl_fall, start_det, stop_det;

  smb_rst_sync u_rst (.clk(clk), .arst_n(rst_n), .rst_sn(rst_sn));

  smb_line_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_sn), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  eng_state_e       state_q, state_d, after_q, after_d;
  logic             rdph_q, rdph_d;
  logic [2:0]       cnt_q, cnt_d;
  logic [7:0]       sh_q, sh_d;
  logic [LEN_W-1:0] idx_q, idx_d, n_q, n_d;
  logic             pec_q, pec_d;
  logic [7:0]       crc_q, crc_d, crc_din, crc_nx;
  logic             crc_en;
  logic             oe_q, oe_d;

  logic             bus_evt;
  logic [7:0]       rx_byte, cnt_byte, nxt_byte;
  logic [LEN_W-1:0] len_cl, last_idx;

  smb_crc8_step #(.POLY(CRC_POLY)) u_crc (.crc_i(crc_q), .data_i(crc_din), .crc_o(crc_nx));

  assign bus_evt  = scl_rise | scl_fall | start_det | stop_det;
  assign rx_byte  = {sh_q[6:0], sda_s};
  assign len_cl   = (blk_len == '0 || blk_len > LEN_W'(MAX_LEN)) ? LEN_W'(MAX_LEN) : blk_len;
  assign cnt_byte = 8'(len_cl);
  assign last_idx = n_q + LEN_W'(pec_q);
  assign rd_addr  = AW'(idx_q - 1'b1);
  assign nxt_byte = (idx_q <= n_q) ? rd_data : crc_q;
  assign sda_oe   = oe_q;

  // next-state logic
  always_comb begin
    state_d = state_q;
    after_d = after_q;
    rdph_d  = rdph_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    idx_d   = idx_q;
    n_d     = n_q;
    pec_d   = pec_q;
    oe_d    = oe_q;
    crc_d   = crc_q;
    crc_din = rx_byte;
    crc_en  = 1'b0;

    if (stop_det) begin
      state_d = S_IDLE;
      oe_d    = 1'b0;
    end else if (start_det) begin
      state_d = S_ADDR;
      oe_d    = 1'b0;
      cnt_d   = '0;
      rdph_d  = (state_q == S_RSW);
      if (state_q != S_RSW) crc_d = '0;
    end else begin
      unique case (state_q)
        S_ADDR, S_CMD: if (scl_rise) begin
          sh_d  = rx_byte;
          cnt_d = cnt_q + 3'd1;
          if (cnt_q == 3'd7) begin
            if (state_q == S_ADDR && rx_byte == {DEV_ADDR, rdph_q}) begin
              crc_en  = 1'b1;
              state_d = S_ACK;
              after_d = rdph_q ? S_TX : S_CMD;
            end else if (state_q == S_CMD && rx_byte == CMD_CODE) begin
              crc_en  = 1'b1;
              state_d = S_ACK;
              after_d = S_RSW;
            end else begin
              state_d = S_IDLE;
            end
          end
        end
        S_ACK: if (scl_fall) begin
          if (!oe_q) begin
            oe_d = 1'b1;
          end else if (after_q == S_TX) begin
            idx_d   = '0;
            n_d     = len_cl;
            pec_d   = pec_en;
            sh_d    = cnt_byte;
            crc_din = cnt_byte;
            crc_en  = 1'b1;
            oe_d    = ~cnt_byte[7];
            cnt_d   = '0;
            state_d = S_TX;
          end else begin
            oe_d    = 1'b0;
            cnt_d   = '0;
            state_d = after_q;
          end
        end
        S_TX: begin
          if (scl_rise) begin
            cnt_d = cnt_q + 3'd1;
            if (cnt_q == 3'd7) state_d = S_TXACK;
          end
          if (scl_fall) begin
            sh_d = {sh_q[6:0], 1'b0};
            oe_d = ~sh_q[6];
          end
        end
        S_TXACK: begin
          if (scl_fall) oe_d = 1'b0;
          if (scl_rise) begin
            if (!sda_s && idx_q != last_idx) begin
              idx_d   = idx_q + 1'b1;
              state_d = S_TXNXT;
            end else begin
              state_d = S_WAIT;
            end
          end
        end
        S_TXNXT: if (scl_fall) begin
          sh_d    = nxt_byte;
          crc_din = rd_data;
          crc_en  = (idx_q <= n_q);
          oe_d    = ~nxt_byte[7];
          cnt_d   = '0;
          state_d = S_TX;
        end
        default: ;
      endcase
    end
    if (crc_en) crc_d = crc_nx;
  end

  // registers, advanced only on bus events
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      state_q <= S_IDLE;
      after_q <= S_IDLE;
      rdph_q  <= 1'b0;
      cnt_q   <= '0;
      sh_q    <= '0;
      idx_q   <= '0;
      n_q     <= '0;
      pec_q   <= 1'b0;
      crc_q   <= '0;
      oe_q    <= 1'b0;
    end else if (bus_evt) begin
      state_q <= state_d;
      after_q <= after_d;
      rdph_q  <= rdph_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      idx_q   <= idx_d;
      n_q     <= n_d;
      pec_q   <= pec_d;
      crc_q   <= crc_d;
      oe_q    <= oe_d;
    end
  end
endmodule

// File: rtl/smb_blk_rd_pec_chk.sv
module smb_blk_rd_pec_chk
  import smb_blk_pkg::*;
#(
  parameter int LEN_W   = 6,
  parameter int MAX_LEN = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_i,
  input logic             sda_oe,
  input eng_state_e       state_q,
  input logic [LEN_W-1:0] idx_q,
  input logic [LEN_W-1:0] n_q,
  input logic             pec_q
);
  a_r10_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i);

  a_r9_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_IDLE) |-> !sda_oe);

  a_r8_wait_released: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_WAIT) |-> !sda_oe);

  a_r3_rsw_released: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_RSW) |-> !sda_oe);

  a_r5_len_range: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_TX) |-> (n_q >= LEN_W'(1) && n_q <= LEN_W'(MAX_LEN)));

  a_r6_idx_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_TX) |-> ({1'b0, idx_q} <= {1'b0, n_q} + (LEN_W+1)'(pec_q)));

  a_r4_tx_starts_at_count: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_TX && $past(state_q) == S_ACK) |-> (idx_q == '0));
endmodule

bind smb_blk_rd_pec smb_blk_rd_pec_chk #(.LEN_W(LEN_W), .MAX_LEN(MAX_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
  .state_q(state_q), .idx_q(idx_q), .n_q(n_q), .pec_q(pec_q)
);

// File: tb/sim_smb_blk_rd_pec.sv
`timescale 1ns/1ps
module sim_smb_blk_rd_pec;
  localparam logic [6:0] DEV = 7'h2C;
  localparam int H = 8;  // clocks per SCL half period

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic       scl_i, sda_i, sda_oe;
  logic       pec_en = 1'b0;
  logic [5:0] blk_len = 6'd1;
  logic [4:0] rd_addr;
  logic [7:0] rd_data;
  logic [7:0] mem [32];
  int         n_chk = 0, n_bad = 0, r10_bad = 0;
  logic       prev_oe = 1'b0;
  logic       done = 1'b0;

  always #4 clk = ~clk;

  assign scl_i   = scl_m;
  assign sda_i   = sda_m & ~sda_oe;
  assign rd_data = mem[rd_addr];

  smb_blk_rd_pec u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .sda_oe(sda_oe),
    .pec_en(pec_en), .blk_len(blk_len), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // R10 monitor: the target may only move SDA while SCL is low
  always @(posedge clk) begin
    if (rst_n && sda_oe != prev_oe && scl_m) r10_bad++;
    prev_oe <= sda_oe;
  end

  function automatic logic [7:0] crc_upd(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    logic       fb;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      fb = r[7] ^ d[i];
      r  = {r[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
    end
    return r;
  endfunction

  function automatic int clamp_len(input logic [5:0] l);
    return (l == 0 || l > 32) ? 32 : int'(l);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(H/2);
    scl_m = 1'b1; tick(H);
    sda_m = 1'b0; tick(H);
    scl_m = 1'b0; tick(H/2);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(H/2);
    scl_m = 1'b1; tick(H);
    sda_m = 1'b1; tick(H);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; tick(H/2);
    scl_m = 1'b1; tick(H);
    scl_m = 1'b0; tick(H/2);
  endtask

  task automatic get_bit(output logic v);
    sda_m = 1'b1; tick(H/2);
    scl_m = 1'b1; tick(H/2);
    v = sda_i; tick(H/2);
    scl_m = 1'b0; tick(H/2);
  endtask

  task automatic put_byte(input logic [7:0] b, output logic acked);
    logic a;
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    get_bit(a);
    acked = ~a;
  endtask

  task automatic get_byte(input logic send_ack, output logic [7:0] b);
    logic v;
    for (int i = 7; i >= 0; i--) begin
      get_bit(v);
      b[i] = v;
    end
    put_bit(~send_ack);
  endtask

  // full block read; nack_at > 0 ends the read early after that many bytes
  task automatic block_read(input logic [5:0] len, input logic pec, input int nack_at);
    logic       ack;
    logic [7:0] b, e_b, crc;
    int         e, total, stop_at;
    blk_len = len;
    pec_en  = pec;
    e       = clamp_len(len);
    total   = 1 + e + (pec ? 1 : 0);
    stop_at = (nack_at > 0 && nack_at < total) ? nack_at : total;
    crc     = 8'h00;
    bus_start();
    put_byte({DEV, 1'b0}, ack);  check("R1 write address ACK", ack, 1);
    crc = crc_upd(crc, {DEV, 1'b0});
    put_byte(8'hFD, ack);        check("R2 block-read command ACK", ack, 1);
    crc = crc_upd(crc, 8'hFD);
    bus_start();
    put_byte({DEV, 1'b1}, ack);  check("R3 read address ACK", ack, 1);
    crc = crc_upd(crc, {DEV, 1'b1});
    for (int k = 0; k < stop_at; k++) begin
      get_byte(k != stop_at - 1, b);
      if (k == 0) begin
        e_b = 8'(e);
        check("R5 count byte", b, e_b);
      end else if (k <= e) begin
        e_b = mem[k-1];
        check("R4 data byte", b, e_b);
      end else begin
        e_b = crc;
        check("R6 PEC byte", b, e_b);
      end
      crc = crc_upd(crc, e_b);
    end
    get_byte(1'b0, b);
    if (stop_at < total) check("R8 silent after early NACK", b, 8'hFF);
    else                 check("R7 released after final byte", b, 8'hFF);
    bus_stop();
  endtask

  initial begin
    int wd = 0;
    while (!done) begin
      @(posedge clk);
      wd++;
      if (wd > 150000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: got %0d cycles expected below 150000", wd);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    logic ack;
    int   l, na, tot;
    logic p;
    void'($urandom(32'h5EED_0063));
    for (int i = 0; i < 32; i++) mem[i] = 8'($urandom);
    tick(5);
    check("R9 SDA released in reset", sda_oe, 0);
    rst_n = 1'b1;
    tick(5);
    check("R9 SDA released after reset", sda_oe, 0);

    // wrong device address
    bus_start();
    put_byte({DEV ^ 7'h01, 1'b0}, ack); check("R1 foreign address NACK", ack, 0);
    bus_stop();

    // unknown command, then read address must also be refused
    bus_start();
    put_byte({DEV, 1'b0}, ack); check("R1 write address ACK", ack, 1);
    put_byte(8'h42, ack);       check("R2 unknown command NACK", ack, 0);
    bus_start();
    put_byte({DEV, 1'b1}, ack); check("R2 read address after bad command NACK", ack, 0);
    bus_stop();

    // read address without any write phase
    bus_start();
    put_byte({DEV, 1'b1}, ack); check("R3 read address without command NACK", ack, 0);
    bus_stop();

    // aborted write phase: stop after the address
    bus_start();
    put_byte({DEV, 1'b0}, ack); check("R9 address before abort", ack, 1);
    bus_stop();
    check("R9 SDA released after stop", sda_oe, 0);

    block_read(6'd1, 1'b1, 0);
    block_read(6'd32, 1'b0, 0);
    block_read(6'd0, 1'b1, 0);
    block_read(6'd40, 1'b1, 0);
    block_read(6'd33, 1'b0, 0);
    block_read(6'd10, 1'b1, 3);
    block_read(6'd5, 1'b0, 1);

    for (int t = 0; t < 10; t++) begin
      l   = int'($urandom % 40);
      p   = 1'($urandom);
      tot = 1 + clamp_len(6'(l)) + (p ? 1 : 0);
      na  = ($urandom % 4 == 0) ? 1 + int'($urandom % tot) : 0;
      block_read(6'(l), p, na);
    end

    check("R10 SDA moved while SCL high", r10_bad, 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule